// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block is the control register bank of a link-layer host controller. Software reaches it through a simple 32-bit read/write bus. The bus carries a byte offset inside a 2 KB window. Control state is never written as a whole word. Each control register has two addresses. A 1 written to the set address turns the matching bits on, and a 1 written to the clear address turns them off. Because of this, software never needs a read-modify-write sequence to change one bit.

The bank holds four kinds of state:
- a fixed version word;
- a plain read/write retry-count word;
- a host-control register, exposed through a set/clear pair;
- an interrupt event register and an interrupt mask register, each with its own set/clear pair.

Hardware event lines raise event bits directly. A single interrupt line reports whether any event bit is enabled by its mask bit. A read of the event clear address returns only the enabled events.

There are two resets. The global reset clears everything. The soft reset clears everything except a configurable set of host-control bits, which only the global reset can clear.

Top module: `lhc_regbank`

## Requirements
- R1: After the global reset `rst`, the retry, host-control, event and mask registers all read 0, `hc_ctrl` is 0, and `irq_out` is 0. The version word reads `VERSION_VALUE`, which defaults to 32'h0001_0010.
- R2: A write to a set address forces to 1 every register bit whose data bit is 1, and leaves the other bits unchanged.
- R3: A write to a clear address forces to 0 every register bit whose data bit is 1, and leaves the other bits unchanged.
- R4: A read pulse on `bus_rd` produces `bus_rvalid` and `bus_rdata` one clock later. Reading either the set address or the clear address of host-control returns the raw contents. The same holds for the mask register.
- R5: A read of the event clear address (84h) returns the event bits ANDed with the mask bits. A read of the event set address (80h) returns the raw event bits.
- R6: The register map is as follows. Bits [1:0] of the byte offset are ignored.

  | Byte offset | Register |
  |---|---|
  | 00h | version |
  | 08h | retry count |
  | 50h | host-control set |
  | 54h | host-control clear |
  | 80h | event set |
  | 84h | event clear |
  | 88h | mask set |
  | 8Ch | mask clear |

- R7: A `soft_rst` pulse clears the retry, event and mask registers. In the host-control register it keeps only the bits in `HC_KEEP_MASK`, which defaults to 32'h8000_0001.
- R8: A read of any unmapped offset returns 0. A write to an unmapped offset changes nothing, and a write to the version word changes nothing.
- R9: A 1 on a bit of `hw_event` sets that event bit at the same clock edge. If the same bit is also written through the clear address in that cycle, the bit ends up set.
- R10: `irq_out` is registered. One clock after the stored event and mask registers have any common 1 bit, `irq_out` is 1. One clock after they have none, it is 0.
- R11: `hc_ctrl` always shows the current host-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| soft_rst | input | 1 | Soft synchronous reset, active high; keeps the protected host-control bits |
| bus_addr | input | 11 | Byte offset in the 2 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| hw_event | input | 32 | Hardware event set lines, one per event bit |
| hc_ctrl | output | 32 | Current host-control register |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume three things about the inputs:
- `bus_wr` and `bus_rd` are never high in the same cycle;
- a single write targets one register;
- the global reset is held at the first clock edge.

The write-one-to-clear property also allows for `hw_event` bits that collide with the clear. The stimulus keeps each bus access to a one-cycle strobe, driven between clock edges. It releases `hw_event` after one cycle, and it raises `soft_rst` only while the bus is idle.

// File: rtl/lhc_regbank_pkg.sv
package lhc_regbank_pkg;

  // Word indices (byte offset >> 2) of the mapped registers
  localparam int unsigned WIX_VERSION = 'h00;
  localparam int unsigned WIX_RETRY   = 'h02;
  localparam int unsigned WIX_HC_SET  = 'h14;
  localparam int unsigned WIX_HC_CLR  = 'h15;
  localparam int unsigned WIX_EV_SET  = 'h20;
  localparam int unsigned WIX_EV_CLR  = 'h21;
  localparam int unsigned WIX_MK_SET  = 'h22;
  localparam int unsigned WIX_MK_CLR  = 'h23;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_VERSION,
    REG_RETRY,
    REG_HC_SET,
    REG_HC_CLR,
    REG_EV_SET,
    REG_EV_CLR,
    REG_MK_SET,
    REG_MK_CLR
  } reg_id_t;

endpackage

// File: rtl/lhc_addr_decode.sv
module lhc_addr_decode
  import lhc_regbank_pkg::*;
#(
  parameter int unsigned WORD_W = 9
) (
  input  logic [WORD_W-1:0] word_idx,
  output reg_id_t           reg_id
);

  always_comb begin
    unique case (int'(word_idx))
      WIX_VERSION: reg_id = REG_VERSION;
      WIX_RETRY:   reg_id = REG_RETRY;
      WIX_HC_SET:  reg_id = REG_HC_SET;
      WIX_HC_CLR:  reg_id = REG_HC_CLR;
      WIX_EV_SET:  reg_id = REG_EV_SET;
      WIX_EV_CLR:  reg_id = REG_EV_CLR;
      WIX_MK_SET:  reg_id = REG_MK_SET;
      WIX_MK_CLR:  reg_id = REG_MK_CLR;
      default:     reg_id = REG_NONE;
    endcase
  end

endmodule

// File: rtl/lhc_setclr_reg.sv
module lhc_setclr_reg #(
  parameter int unsigned          WIDTH     = 32,
  parameter logic [WIDTH-1:0]     KEEP_MASK = '0,
  parameter bit                   HW_SET_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] hw_bits;
  logic [WIDTH-1:0] q_sw;
  logic [WIDTH-1:0] q_next;

  generate
    if (HW_SET_EN) begin : g_hw
      assign hw_bits = hw_set;
    end else begin : g_no_hw
      logic unused_hw;
      assign unused_hw = ^hw_set;
      assign hw_bits   = '0;
    end
  endgenerate

  always_comb begin
    q_sw = q;
    if (set_we) q_sw = q_sw | wdata;
    if (clr_we) q_sw = q_sw & ~wdata;
    q_next = q_sw | hw_bits;     // hardware set wins over a software clear
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (soft_rst) q <= q & KEEP_MASK;
    else               q <= q_next;
  end

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (rst)
    (set_we && !soft_rst) |=> ((q & $past(wdata)) == $past(wdata))); // R2

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !soft_rst) |=> ((q & $past(wdata) & ~$past(hw_bits)) == '0)); // R3

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((hw_bits != '0) && !soft_rst) |=> ((q & $past(hw_bits)) == $past(hw_bits))); // R9

  AST_SOFT_KEEPS_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (q == ($past(q) & KEEP_MASK))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we && (hw_bits == '0) && !soft_rst) |=> $stable(q)); // R8

endmodule

// File: rtl/lhc_read_mux.sv
module lhc_read_mux
  import lhc_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_id_t           reg_id,
  input  logic [DATA_W-1:0] version,
  input  logic [DATA_W-1:0] retry,
  input  logic [DATA_W-1:0] hc,
  input  logic [DATA_W-1:0] ev,
  input  logic [DATA_W-1:0] mk,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] sel_data;

  always_comb begin
    unique case (reg_id)
      REG_VERSION:            sel_data = version;
      REG_RETRY:              sel_data = retry;
      REG_HC_SET, REG_HC_CLR: sel_data = hc;
      REG_EV_SET:             sel_data = ev;
      REG_EV_CLR:             sel_data = ev & mk;   // masked view
      REG_MK_SET, REG_MK_CLR: sel_data = mk;
      default:                sel_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel_data;
    end
  end

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R4

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_id == REG_NONE) |=> (rdata == '0)); // R8

  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_id == REG_EV_CLR) |=> ((rdata & ~$past(mk)) == '0)); // R5

endmodule

// File: rtl/lhc_regbank.sv
module lhc_regbank
  import lhc_regbank_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 11,
  parameter int unsigned        DATA_W        = 32,
  parameter logic [DATA_W-1:0]  VERSION_VALUE = 32'h0001_0010,
  parameter logic [DATA_W-1:0]  HC_KEEP_MASK  = 32'h8000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] hw_event,
  output logic [DATA_W-1:0] hc_ctrl,
  output logic              irq_out
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  reg_id_t           reg_id;
  logic [DATA_W-1:0] retry_q;
  logic [DATA_W-1:0] hc_q;
  logic [DATA_W-1:0] ev_q;
  logic [DATA_W-1:0] mk_q;
  logic              irq_q;
  logic              unused_lsb;

  assign unused_lsb = ^bus_addr[1:0];

  lhc_addr_decode #(.WORD_W(WORD_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .reg_id   (reg_id)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst)                    retry_q <= '0;
    else if (bus_wr && reg_id == REG_RETRY) retry_q <= bus_wdata;
  end

  lhc_setclr_reg #(.WIDTH(DATA_W), .KEEP_MASK(HC_KEEP_MASK), .HW_SET_EN(1'b0)) u_hc (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .set_we   (bus_wr && reg_id == REG_HC_SET),
    .clr_we   (bus_wr && reg_id == REG_HC_CLR),
    .wdata    (bus_wdata),
    .hw_set   ('0),
    .q        (hc_q)
  );

  lhc_setclr_reg #(.WIDTH(DATA_W), .KEEP_MASK('0), .HW_SET_EN(1'b1)) u_ev (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .set_we   (bus_wr && reg_id == REG_EV_SET),
    .clr_we   (bus_wr && reg_id == REG_EV_CLR),
    .wdata    (bus_wdata),
    .hw_set   (hw_event),
    .q        (ev_q)
  );

  lhc_setclr_reg #(.WIDTH(DATA_W), .KEEP_MASK('0), .HW_SET_EN(1'b0)) u_mk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .set_we   (bus_wr && reg_id == REG_MK_SET),
    .clr_we   (bus_wr && reg_id == REG_MK_CLR),
    .wdata    (bus_wdata),
    .hw_set   ('0),
    .q        (mk_q)
  );

  lhc_read_mux #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .reg_id  (reg_id),
    .version (VERSION_VALUE),
    .retry   (retry_q),
    .hc      (hc_q),
    .ev      (ev_q),
    .mk      (mk_q),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) irq_q <= 1'b0;
    else                 irq_q <= |(ev_q & mk_q);
  end

  assign irq_out = irq_q;
  assign hc_ctrl = hc_q;

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> (irq_out == |($past(ev_q) & $past(mk_q)))); // R10

  AST_SOFT_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !irq_out); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (hc_ctrl == '0 && !irq_out && !bus_rvalid)); // R1

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R4

endmodule

// File: tb/lhc_regbank_bench.sv
module lhc_regbank_bench;

  localparam logic [31:0] VER  = 32'h0001_0010;
  localparam logic [31:0] KEEP = 32'h8000_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] hw_event = '0;
  logic [31:0] hc_ctrl;
  logic        irq_out;

  always #5 clk = ~clk;

  lhc_regbank u_lhc_regbank (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .hw_event(hw_event),
    .hc_ctrl(hc_ctrl), .irq_out(irq_out)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Model of the register state, built from the requirements
  logic [31:0] m_rt = '0, m_hc = '0, m_ev = '0, m_mk = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [31:0] d, input logic [31:0] hw);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; hw_event = hw;
    @(negedge clk);
    bus_wr = 1'b0; hw_event = '0;
    case (a[10:2])
      9'h02: m_rt = d;
      9'h14: m_hc = m_hc | d;
      9'h15: m_hc = m_hc & ~d;
      9'h20: m_ev = m_ev | d;
      9'h21: m_ev = m_ev & ~d;
      9'h22: m_mk = m_mk | d;
      9'h23: m_mk = m_mk & ~d;
      default: ;
    endcase
    m_ev = m_ev | hw;
  endtask

  task automatic bus_read(input logic [10:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R4: unexpected rvalid, actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 hc_ctrl after reset", hc_ctrl, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    bus_read(11'h000, VER, "R1 R6 version");
    bus_read(11'h008, 32'h0, "R1 retry reset");
    bus_read(11'h080, 32'h0, "R1 event reset");
    bus_read(11'h088, 32'h0, "R1 mask reset");

    bus_write(11'h008, 32'h0000_005A, '0);
    bus_read(11'h008, m_rt, "R6 retry rw");
    bus_write(11'h000, 32'hFFFF_FFFF, '0);
    bus_read(11'h000, VER, "R8 version write ignored");

    bus_write(11'h050, 32'h8000_00F1, '0);
    check("R11 hc_ctrl after set", hc_ctrl, m_hc);
    bus_read(11'h050, m_hc, "R2 R4 hc via set addr");
    bus_read(11'h054, m_hc, "R4 hc via clear addr");
    bus_write(11'h054, 32'h0000_0030, '0);
    bus_read(11'h050, 32'h8000_00C1, "R3 hc clear");
    check("R11 hc_ctrl after clear", hc_ctrl, 32'h8000_00C1);
    bus_read(11'h053, m_hc, "R6 low addr bits ignored");

    bus_write(11'h200, 32'hDEAD_BEEF, '0);
    bus_read(11'h200, 32'h0, "R8 unmapped read zero");
    bus_read(11'h004, 32'h0, "R8 reserved offset zero");
    bus_read(11'h050, m_hc, "R8 unmapped write no effect");

    bus_write(11'h080, 32'h0000_000F, '0);
    @(negedge clk);
    check("R10 irq without mask", {31'b0, irq_out}, 32'h0);
    bus_write(11'h088, 32'h0000_0005, '0);
    @(negedge clk);
    check("R10 irq with mask", {31'b0, irq_out}, 32'h1);
    bus_read(11'h084, 32'h0000_0005, "R5 masked view");
    bus_read(11'h080, 32'h0000_000F, "R5 raw view");
    bus_read(11'h08C, 32'h0000_0005, "R4 mask via clear addr");
    bus_write(11'h084, 32'h0000_0005, '0);
    bus_read(11'h080, 32'h0000_000A, "R3 event clear");
    check("R10 irq drops", {31'b0, irq_out}, 32'h0);
    bus_read(11'h084, 32'h0, "R5 masked view empty");

    bus_write(11'h1F0, 32'h0, 32'h0000_0100);
    bus_read(11'h080, m_ev, "R9 hw event sets");
    bus_write(11'h084, 32'h0000_0002, 32'h0000_0002);
    bus_read(11'h080, 32'h0000_010A, "R9 hw set beats clear");
    bus_write(11'h084, 32'h0000_0002, '0);
    bus_read(11'h080, 32'h0000_0108, "R3 event clear later");
    bus_write(11'h08C, 32'h0000_0001, '0);
    bus_read(11'h088, 32'h0000_0004, "R3 mask clear");

    bus_write(11'h080, 32'h0000_0004, '0);
    @(negedge clk);
    check("R10 irq before soft reset", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    m_hc = m_hc & KEEP; m_ev = '0; m_mk = '0; m_rt = '0;
    check("R7 hc keeps protected bits", hc_ctrl, 32'h8000_0001);
    check("R7 irq cleared", {31'b0, irq_out}, 32'h0);
    bus_read(11'h080, 32'h0, "R7 event cleared");
    bus_read(11'h088, 32'h0, "R7 mask cleared");
    bus_read(11'h008, 32'h0, "R7 retry cleared");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 global reset clears protected", hc_ctrl, 32'h0);
    bus_read(11'h054, 32'h0, "R1 hc after global reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; errors++;
      $display("FAIL R4: missing reads, actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule